// File: doc/BRIEF.md
# Circular Return-Address Stack

This block keeps the return addresses of a small microcontroller core. When the core calls a subroutine or takes an interrupt, it pushes the address to come back to. When it executes any return-type instruction, it pops that address. The storage is private to the block and is not mapped into program or data space. The write/read pointer stays inside the block, and software cannot reach it.

The stack holds a fixed number of entries and wraps around with no warning. A push beyond the depth replaces the oldest live entry. A pop beyond the live entries reads whatever the wrapped slot still holds. The block raises no flag for either case. The current top of stack is always present on the output, so on the cycle of a pop the core takes the return address straight from that port.

Top module: `hw_ret_stack`

## Requirements
- R1: A push stores `push_addr_i`. From the clock edge that takes the push, `tos_o` shows that address.
- R2: `tos_o` always shows the most recent entry that has not been popped. A pop without a push makes the previous entry visible after the clock edge, in last-in-first-out order.
- R3: With the default depth of 8, eight pushes that follow a reset can all be recovered. Pops return them in reverse order.
- R4: The ninth push in a row overwrites the first entry, and the tenth overwrites the second. No status output exists for this condition.
- R5: After eight pushes and eight pops, `tos_o` wraps and shows the eighth value pushed. A further pop shows the seventh value. No status output exists for this condition.
- R6: Reset sets the internal pointer to zero and leaves the stored entries as they were. After reset, a push followed by a pop exposes the entry held in the last slot (slot 7).
- R7: When push and pop are both asserted in one cycle, the push is taken and the pop is ignored. A later pop returns the top of stack as it was before that cycle.
- R8: In a cycle with neither strobe, the pointer and `tos_o` do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset of the pointer |
| push_i | input | 1 | Push strobe (subroutine call or interrupt entry) |
| push_addr_i | input | 13 | Return address to store on a push |
| pop_i | input | 1 | Pop strobe (any return instruction) |
| tos_o | output | 13 | Current top-of-stack address |

## Verification
Every result of this block appears one clock edge after the strobe that causes it. Pushes and pops update registers, and `tos_o` is read from those registers through a read multiplexer with no further register stage. The bench therefore drives each strobe on a falling edge and samples `tos_o` on the next falling edge, half a period after the rising edge that acted on the strobe. The wrap and overwrite cases are checked the same way, pop by pop, against values the bench chose for each slot.

// File: rtl/rstk_pkg.sv
package rstk_pkg;

  localparam int unsigned DEF_DEPTH = 8;
  localparam int unsigned DEF_AW    = 13;

  // Slot index following p on a ring of the given size.
  function automatic int unsigned ring_next(int unsigned p, int unsigned depth);
    return (p + 1) % depth;
  endfunction

  // Slot index preceding p on a ring of the given size.
  function automatic int unsigned ring_prev(int unsigned p, int unsigned depth);
    return (p + depth - 1) % depth;
  endfunction

endpackage

// File: rtl/rstk_ptr.sv
module rstk_ptr #(
  parameter int unsigned DEPTH = rstk_pkg::DEF_DEPTH,
  localparam int unsigned PW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_evt,
  input  logic          pop_evt,
  output logic [PW-1:0] ptr_q,
  output logic [PW-1:0] wr_slot,
  output logic [PW-1:0] rd_slot
);

  logic [PW-1:0] ptr_inc;
  logic [PW-1:0] ptr_dec;

  assign ptr_inc = PW'(rstk_pkg::ring_next(32'(ptr_q), DEPTH));
  assign ptr_dec = PW'(rstk_pkg::ring_prev(32'(ptr_q), DEPTH));

  // The push writes at the pointer; the top of stack sits one slot below it.
  assign wr_slot = ptr_q;
  assign rd_slot = ptr_dec;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (push_evt) begin
      ptr_q <= ptr_inc;
    end else if (pop_evt) begin
      ptr_q <= ptr_dec;
    end
  end

endmodule

// File: rtl/rstk_store.sv
module rstk_store #(
  parameter int unsigned DEPTH = rstk_pkg::DEF_DEPTH,
  parameter int unsigned AW    = rstk_pkg::DEF_AW,
  localparam int unsigned PW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [PW-1:0] wr_slot,
  input  logic [AW-1:0] wr_data,
  input  logic [PW-1:0] rd_slot,
  output logic [AW-1:0] rd_data
);

  logic [AW-1:0] slot_q [DEPTH];

  // One register row per slot. There is no reset: contents survive it.
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic hit;
    assign hit = wr_en && (wr_slot == PW'(g));
    always_ff @(posedge clk) begin
      if (hit) begin
        slot_q[g] <= wr_data;
      end
    end
  end

  assign rd_data = slot_q[rd_slot];

endmodule

// File: rtl/hw_ret_stack.sv
module hw_ret_stack #(
  parameter int unsigned DEPTH = rstk_pkg::DEF_DEPTH,
  parameter int unsigned AW    = rstk_pkg::DEF_AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic [AW-1:0] push_addr_i,
  input  logic          pop_i,
  output logic [AW-1:0] tos_o
);

  localparam int unsigned PW = $clog2(DEPTH);

  // Named events, visible to the bound checker.
  logic          push_evt;
  logic          pop_evt;
  logic [PW-1:0] ptr_q;
  logic [PW-1:0] wr_slot;
  logic [PW-1:0] rd_slot;

  // A push outranks a pop in the same cycle.
  assign push_evt = push_i;
  assign pop_evt  = pop_i && !push_i;

  rstk_ptr #(.DEPTH(DEPTH)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .push_evt (push_evt),
    .pop_evt  (pop_evt),
    .ptr_q    (ptr_q),
    .wr_slot  (wr_slot),
    .rd_slot  (rd_slot)
  );

  rstk_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
    .clk     (clk),
    .wr_en   (push_evt),
    .wr_slot (wr_slot),
    .wr_data (push_addr_i),
    .rd_slot (rd_slot),
    .rd_data (tos_o)
  );

endmodule

// File: rtl/rstk_chk.sv
module rstk_chk #(
  parameter int unsigned DEPTH = rstk_pkg::DEF_DEPTH,
  parameter int unsigned AW    = rstk_pkg::DEF_AW,
  localparam int unsigned PW   = $clog2(DEPTH)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          push_i,
  input logic [AW-1:0] push_addr_i,
  input logic          pop_i,
  input logic [AW-1:0] tos_o,
  input logic [PW-1:0] ptr_q
);

  // R1
  push_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_i |=> tos_o == $past(push_addr_i));

  // R2
  pop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !push_i) |=> 32'(ptr_q) == (32'($past(ptr_q)) + DEPTH - 1) % DEPTH);

  // R7
  push_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && pop_i) |=> 32'(ptr_q) == (32'($past(ptr_q)) + 1) % DEPTH);

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!push_i && !pop_i) |=> ($stable(ptr_q) && $stable(tos_o)));

  // R6
  reset_ptr_chk: assert property (@(posedge clk)
    !rst_n |=> ptr_q == '0);

endmodule

bind hw_ret_stack rstk_chk #(.DEPTH(DEPTH), .AW(AW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .push_i      (push_i),
  .push_addr_i (push_addr_i),
  .pop_i       (pop_i),
  .tos_o       (tos_o),
  .ptr_q       (ptr_q)
);

// File: tb/hw_ret_stack_bench.sv
module hw_ret_stack_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        push_i = 1'b0;
  logic [12:0] push_addr_i = '0;
  logic        pop_i = 1'b0;
  logic [12:0] tos_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  hw_ret_stack u_hw_ret_stack (
    .clk         (clk),
    .rst_n       (rst_n),
    .push_i      (push_i),
    .push_addr_i (push_addr_i),
    .pop_i       (pop_i),
    .tos_o       (tos_o)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 50000 && !done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(string req, logic [12:0] exp);
    checks++;
    if (tos_o !== exp) begin
      errors++;
      $display("FAIL %s: tos_o actual %h expected %h", req, tos_o, exp);
    end
  endtask

  // One clock: drive at a falling edge, result sampled at the next falling edge.
  task automatic step(bit psh, logic [12:0] addr, bit pp);
    push_i = psh;
    push_addr_i = addr;
    pop_i = pp;
    @(negedge clk);
    push_i = 1'b0;
    pop_i = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_push_visible();
    do_reset();
    step(1, 13'h1ABC, 0); check("R1", 13'h1ABC);
    step(1, 13'h0003, 0); check("R1", 13'h0003);
  endtask

  task automatic t_lifo();
    do_reset();
    for (int i = 0; i < 8; i++) begin
      step(1, 13'h0100 + 13'(i), 0);
      check("R1", 13'h0100 + 13'(i));
    end
    for (int k = 1; k < 8; k++) begin
      step(0, '0, 1);
      check("R3", 13'h0100 + 13'(7 - k));
    end
  endtask

  task automatic t_overwrite();
    do_reset();
    for (int i = 0; i < 10; i++) step(1, 13'h0A00 + 13'(i), 0);
    check("R4", 13'h0A09);
    for (int k = 1; k < 8; k++) begin
      step(0, '0, 1);
      check("R4", 13'h0A00 + 13'(9 - k));
    end
    step(0, '0, 1);
    check("R4", 13'h0A09);
  endtask

  task automatic t_underflow();
    do_reset();
    for (int i = 0; i < 8; i++) step(1, 13'h1200 + 13'(i), 0);
    for (int k = 0; k < 8; k++) step(0, '0, 1);
    check("R5", 13'h1207);
    step(0, '0, 1);
    check("R5", 13'h1206);
  endtask

  task automatic t_reset_mid();
    do_reset();
    for (int i = 0; i < 8; i++) step(1, 13'h0C00 + 13'(i), 0);
    for (int k = 0; k < 3; k++) step(0, '0, 1);
    do_reset();
    step(1, 13'h1FFF, 0); check("R6", 13'h1FFF);
    step(0, '0, 1);       check("R6", 13'h0C07);
  endtask

  task automatic t_same_cycle();
    do_reset();
    step(1, 13'h0011, 0);
    step(1, 13'h0022, 0);
    step(1, 13'h0033, 1); check("R7", 13'h0033);
    step(0, '0, 1);       check("R7", 13'h0022);
    step(0, '0, 1);       check("R2", 13'h0011);
  endtask

  task automatic t_idle();
    do_reset();
    step(1, 13'h0555, 0);
    for (int i = 0; i < 5; i++) begin
      step(0, '0, 0);
      check("R8", 13'h0555);
    end
  endtask

  initial begin
    @(negedge clk);
    t_push_visible();
    t_lifo();
    t_overwrite();
    t_underflow();
    t_reset_mid();
    t_same_cycle();
    t_idle();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule